// File: doc/BRIEF.md
# Byte-Wide Arithmetic, Logic and Multi-Bit Shift Unit

This block is the purely combinational arithmetic and logic unit of a small multi-cycle processor. It takes a 4-bit operation code and two byte-wide operands. Operand A is the value of the target register. Operand B is either an immediate taken from the instruction or the value of a second register. The block returns a byte-wide result together with a carry flag and a zero flag, and the processor latches all three into its own registers.

Besides addition, subtraction and the bitwise operations, the unit shifts and rotates by a variable distance. The distance is taken from the low bits of operand B, so one instruction can move a value by up to seven places. The carry flag records the last bit that left or wrapped around the byte. Every operation defines both flags.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) returns A+B modulo 256 as the result. Carry is bit 8 of the 9-bit sum.
- R2: Op code 1 (subtract) returns A-B modulo 256. Carry is 1 exactly when B is greater than A, which is a borrow.
- R3: Op codes 2 (AND), 3 (OR) and 4 (XOR) combine A with B bit by bit. Op code 5 returns the inverse of A and ignores B. All four operations clear carry.
- R4: Op codes 6 (shift left) and 7 (shift right) move A by the count and fill the vacated bits with zero. Carry is the last bit shifted out: A[8-n] for a left shift and A[n-1] for a right shift, where n is the count.
- R5: Op codes 8 (rotate left) and 9 (rotate right) move A circularly by the count. On each step, bit 7 moves to bit 0 (left) or bit 0 moves to bit 7 (right). Carry is the last bit that wrapped, which equals result bit 0 after a left rotate and result bit 7 after a right rotate.
- R6: The count for shifts and rotates is B[2:0]. B[7:3] has no effect on these operations.
- R7: A count of zero on any shift or rotate returns A unchanged and clears carry.
- R8: For every op code, zero is 1 exactly when the 8-bit result is 0x00.
- R9: Op codes 10 to 15 are unused. They return 0x00 with carry 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see R1 to R9) |
| opnd_a | input | 8 | Operand A, the target register value |
| opnd_b | input | 8 | Operand B: immediate, second register value or count |
| result | output | 8 | Operation result |
| flag_c | output | 1 | Carry, borrow or last bit shifted out or wrapped |
| flag_z | output | 1 | Set when the result is 0x00 |

## Verification
The assertions sit in an always_comb block and assume that op_sel, opnd_a and opnd_b are known (not X) and settle together before any of them is read. The bench meets this by changing all three inputs in a single step on the falling clock edge, one half period before it samples the outputs. Operand values include all-zero and all-ones bytes, single set bits, and counts with the upper bits of B set. The unused op codes are covered as well, so every branch of each assertion is exercised with defined inputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOT = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             sum_c,
  output logic [WIDTH-1:0] diff,
  output logic             diff_borrow
);
  logic [WIDTH:0] sum_w;
  logic [WIDTH:0] diff_w;

  always_comb begin
    sum_w       = {1'b0, a} + {1'b0, b};
    diff_w      = {1'b0, a} - {1'b0, b};
    sum         = sum_w[WIDTH-1:0];
    sum_c       = sum_w[WIDTH];
    diff        = diff_w[WIDTH-1:0];
    diff_borrow = diff_w[WIDTH];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] not_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
    assign xor_o[i] = a[i] ^ b[i];
    assign not_o[i] = ~a[i];
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int WIDTH   = 8,
  parameter bit LEFT    = 1'b1,
  localparam int CNT_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [CNT_W-1:0] cnt,
  output logic [WIDTH-1:0] shifted,
  output logic [WIDTH-1:0] rotated,
  output logic             last_out
);
  logic [2*WIDTH-1:0] ext;
  logic               cnt_nz;

  assign cnt_nz = |cnt;

  if (LEFT) begin : g_left
    // value in low half; bits pushed past the top land in the upper half
    assign ext      = {{WIDTH{1'b0}}, a} << cnt;
    assign shifted  = ext[WIDTH-1:0];
    assign rotated  = ext[WIDTH-1:0] | ext[2*WIDTH-1:WIDTH];
    assign last_out = cnt_nz & ext[WIDTH];
  end else begin : g_right
    // value in upper half; bits pushed past the bottom land in the lower half
    assign ext      = {a, {WIDTH{1'b0}}} >> cnt;
    assign shifted  = ext[2*WIDTH-1:WIDTH];
    assign rotated  = ext[2*WIDTH-1:WIDTH] | ext[WIDTH-1:0];
    assign last_out = cnt_nz & ext[WIDTH-1];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int WIDTH  = 8,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             flag_c,
  output logic             flag_z
);
  import alu8_pkg::*;

  logic [WIDTH-1:0] sum, diff, and_v, or_v, xor_v, not_v;
  logic             sum_c, diff_bw;
  logic [WIDTH-1:0] shl_v, shr_v, rol_v, ror_v;
  logic             lc, rc;
  logic [CNT_W-1:0] cnt;

  assign cnt = opnd_b[CNT_W-1:0];

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .a(opnd_a), .b(opnd_b), .sum(sum), .sum_c(sum_c),
    .diff(diff), .diff_borrow(diff_bw)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b), .and_o(and_v), .or_o(or_v),
    .xor_o(xor_v), .not_o(not_v)
  );

  alu8_shift #(.WIDTH(WIDTH), .LEFT(1'b1)) u_left (
    .a(opnd_a), .cnt(cnt), .shifted(shl_v), .rotated(rol_v), .last_out(lc)
  );

  alu8_shift #(.WIDTH(WIDTH), .LEFT(1'b0)) u_right (
    .a(opnd_a), .cnt(cnt), .shifted(shr_v), .rotated(ror_v), .last_out(rc)
  );

  always_comb begin
    result = '0;
    flag_c = 1'b0;
    case (op_sel)
      OP_ADD: begin result = sum;  flag_c = sum_c;   end
      OP_SUB: begin result = diff; flag_c = diff_bw; end
      OP_AND: result = and_v;
      OP_OR:  result = or_v;
      OP_XOR: result = xor_v;
      OP_NOT: result = not_v;
      OP_SHL: begin result = shl_v; flag_c = lc; end
      OP_SHR: begin result = shr_v; flag_c = rc; end
      OP_ROL: begin result = rol_v; flag_c = lc; end
      OP_ROR: begin result = ror_v; flag_c = rc; end
      default: ;  // unused codes (R9)
    endcase
    flag_z = (result == '0);
  end

  // Assertions relate the muxed outputs to the operands.
  always_comb begin
    if (op_sel == OP_ADD)
      assert_add_sum_R1: assert ({flag_c, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
        else $error("add mismatch");
    if (op_sel == OP_SUB)
      assert_sub_borrow_R2: assert (((result + opnd_b) == opnd_a) && (flag_c == (opnd_b > opnd_a)))
        else $error("subtract mismatch");
    if (op_sel inside {OP_AND, OP_OR, OP_XOR, OP_NOT})
      assert_logic_no_carry_R3: assert (!flag_c) else $error("logic op set carry");
    if ((op_sel inside {OP_SHL, OP_SHR, OP_ROL, OP_ROR}) && (cnt == '0))
      assert_zero_count_R7: assert ((result == opnd_a) && !flag_c)
        else $error("zero count altered value");
    if (op_sel inside {OP_ROL, OP_ROR})
      assert_rot_keeps_ones_R5: assert ($countones(result) == $countones(opnd_a))
        else $error("rotate lost bits");
    if ((op_sel == OP_ROL) && (cnt != '0))
      assert_rol_carry_R5: assert (flag_c == result[0]) else $error("rol carry");
    if ((op_sel == OP_ROR) && (cnt != '0))
      assert_ror_carry_R5: assert (flag_c == result[WIDTH-1]) else $error("ror carry");
    if (op_sel > 4'd9)
      assert_unused_op_R9: assert ((result == '0) && !flag_c && flag_z)
        else $error("unused op not cleared");
    if ((op_sel == OP_NOT) && (opnd_a == '1))
      assert_not_zero_R8: assert (flag_z) else $error("zero flag missed");
  end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  logic       clk = 1'b0;
  logic [3:0] op_sel;
  logic [7:0] opnd_a, opnd_b;
  logic [7:0] result;
  logic       flag_c, flag_z;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u0 (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .flag_c(flag_c), .flag_z(flag_z)
  );

  // {op, a, b, expected result, expected carry, expected zero}
  localparam logic [29:0] VEC [NVEC] = '{
    {4'd0, 8'h3C, 8'h05, 8'h41, 1'b0, 1'b0},
    {4'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},
    {4'd0, 8'h80, 8'h90, 8'h10, 1'b1, 1'b0},
    {4'd1, 8'h10, 8'h01, 8'h0F, 1'b0, 1'b0},
    {4'd1, 8'h01, 8'h02, 8'hFF, 1'b1, 1'b0},
    {4'd1, 8'h55, 8'h55, 8'h00, 1'b0, 1'b1},
    {4'd2, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},
    {4'd3, 8'hA0, 8'h05, 8'hA5, 1'b0, 1'b0},
    {4'd4, 8'h5A, 8'h5A, 8'h00, 1'b0, 1'b1},
    {4'd5, 8'h0F, 8'hAA, 8'hF0, 1'b0, 1'b0},
    {4'd6, 8'h81, 8'h01, 8'h02, 1'b1, 1'b0},
    {4'd6, 8'h0F, 8'h05, 8'hE0, 1'b1, 1'b0},
    {4'd7, 8'h81, 8'h01, 8'h40, 1'b1, 1'b0},
    {4'd7, 8'hF0, 8'h04, 8'h0F, 1'b0, 1'b0},
    {4'd6, 8'h55, 8'h0B, 8'hA8, 1'b0, 1'b0},
    {4'd8, 8'h81, 8'h01, 8'h03, 1'b1, 1'b0},
    {4'd8, 8'h12, 8'h04, 8'h21, 1'b1, 1'b0},
    {4'd9, 8'h01, 8'h01, 8'h80, 1'b1, 1'b0},
    {4'd9, 8'h12, 8'h0C, 8'h21, 1'b0, 1'b0},
    {4'd7, 8'h37, 8'h08, 8'h37, 1'b0, 1'b0},
    {4'd8, 8'h00, 8'h03, 8'h00, 1'b0, 1'b1},
    {4'd12, 8'h77, 8'h11, 8'h00, 1'b0, 1'b1},
    {4'd6, 8'h01, 8'h07, 8'h80, 1'b0, 1'b0},
    {4'd9, 8'hFE, 8'h0F, 8'hFD, 1'b1, 1'b0}
  };

  function automatic string req_tag(input logic [3:0] op, input logic [7:0] b);
    if (op > 4'd9)                            return "R9";
    if ((op >= 4'd6) && (b[2:0] == 3'd0))     return "R7";
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd6, 4'd7: return (b[7:3] != 0) ? "R6" : "R4";
      4'd8, 4'd9: return (b[7:3] != 0) ? "R6" : "R5";
      default: return "R3";
    endcase
  endfunction

  // Step-by-step model: one bit per iteration, as the requirements read.
  function automatic logic [9:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic       c = 1'b0;
    int         n = int'(b[2:0]);
    int         t;
    case (op)
      4'd0: begin t = int'(a) + int'(b); r = t[7:0]; c = t > 255; end
      4'd1: begin t = int'(a) - int'(b); r = t[7:0]; c = int'(b) > int'(a); end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = ~a;
      4'd6, 4'd7, 4'd8, 4'd9: begin
        r = a;
        for (int k = 0; k < n; k++) begin
          case (op)
            4'd6: begin c = r[7]; r = {r[6:0], 1'b0}; end
            4'd7: begin c = r[0]; r = {1'b0, r[7:1]}; end
            4'd8: begin c = r[7]; r = {r[6:0], r[7]}; end
            default: begin c = r[0]; r = {r[0], r[7:1]}; end
          endcase
        end
      end
      default: r = 8'h00;
    endcase
    return {r, c, (r == 8'h00)};
  endfunction

  task automatic apply_check(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                             input logic [9:0] exp, input string tag);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    @(posedge clk);
    #1;
    n_checks++;
    if ({result, flag_c, flag_z} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h : got res=%h c=%b z=%b, expected res=%h c=%b z=%b",
               tag, op, a, b, result, flag_c, flag_z, exp[9:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    logic [7:0] pats [8];
    pats = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'hA5, 8'h7F, 8'hCB};
    // Reset state: all inputs low is an add of zeros, zero flag set (R8, R1)
    apply_check(4'd0, 8'h00, 8'h00, {8'h00, 1'b0, 1'b1}, "R8");
    // Table walk with hand-computed results
    for (int i = 0; i < NVEC; i++)
      apply_check(VEC[i][29:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9:0],
                  req_tag(VEC[i][29:26], VEC[i][17:10]));
    // NOT ignores B: same A with differing B (R3)
    apply_check(4'd5, 8'h3C, 8'h00, {8'hC3, 1'b0, 1'b0}, "R3");
    apply_check(4'd5, 8'h3C, 8'hFF, {8'hC3, 1'b0, 1'b0}, "R3");
    // Upper count bits ignored: B=0xF9 acts as count 1 (R6)
    apply_check(4'd6, 8'h40, 8'hF9, {8'h80, 1'b0, 1'b0}, "R6");
    // Shift everything out, zero flag with carry (R4, R8)
    apply_check(4'd6, 8'h80, 8'h01, {8'h00, 1'b1, 1'b1}, "R4");
    // Sweep of all op codes against the stepwise model
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          apply_check(4'(op), pats[ia], pats[ib] ^ 8'(ib),
                      model(4'(op), pats[ia], pats[ib] ^ 8'(ib)),
                      req_tag(4'(op), pats[ib] ^ 8'(ib)));
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 200000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    #1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule